// File: doc/BRIEF.md
# Dual-Channel Coherent Sine Synthesizer with Buffered Parameter Update

Two numerically controlled oscillator channels run from one system clock, so their phases stay locked to each other. Each channel turns a frequency word, a phase offset and an amplitude scale into a stream of 10-bit signed samples for an external converter. The phase comes from a 32-bit accumulator. A phase offset is added to its upper bits. An arithmetic quarter-wave sine approximation with quadrant folding maps the phase to a sine value, and a multiplier scales that value by the amplitude.

Parameter writes go into per-channel shadow registers and have no effect on the output until an update edge arrives. The block derives a quarter-rate sync clock from the system clock and samples the update input on each of its rising edges. A low-to-high change seen there copies every shadow register of both channels into the active registers in the same system cycle. The sync clock can be muted at its output pin, and the internal sampling continues while it is muted. In normal mode, each parameter passes through its own pipeline depth. In matched mode, all three parameters reach the output after the same delay.

Top module: `dual_dds_core`

## Requirements
- R1: Each channel adds its active 32-bit frequency word to a 32-bit accumulator every system clock, modulo 2^32. The phase index is bits [13:2] of (accumulator[31:18] + phase offset) mod 2^14. The accumulator starts at 0.
- R2: Let p be the 12-bit phase index, with quadrant q = p[11:10] and i = p[9:0]. Take u = 1023 - i when q[0] is 1, otherwise u = i. The magnitude is m = floor(u*(2048-u)/2048). The sine value is -m when q[1] is 1, otherwise +m.
- R3: Each output sample equals floor(sine * amp / 1024), where amp is the active 10-bit unsigned scale. A sample never reaches -512, and a zero scale yields 0.
- R4: sync_clk has a period of four system clocks: high for two, low for two. While sync_en is 0, sync_clk stays low, yet updates are still sampled at the same internal points.
- R5: Shadow writes leave the outputs unchanged until a transfer. A transfer happens at a sync_clk rising edge where io_update is sampled high and the previous sample was low. Holding io_update high causes no further transfer.
- R6: Both channels take a transfer on the same system clock edge and show identical update-to-output delays.
- R7: With match_lat at 0, the first output change comes after 29 system clocks for a frequency change, 25 for a phase change and 17 for an amplitude change. The count starts at the sync_clk rising edge that takes the update.
- R8: With match_lat at 1, phase and amplitude changes also appear 29 system clocks after that edge.
- R9: Reset clears the outputs and accumulators to 0. Frequency and phase reset to 0, and amplitude resets to full scale (1023).
- R10: wr_field selects the target shadow register: 0 is frequency, 1 is phase offset (low 14 bits of wr_data), 2 is amplitude (low 10 bits). Code 3 writes nothing. wr_ch selects the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_en | input | 1 | Drives sync_clk when 1; holds it low when 0 |
| match_lat | input | 1 | Equal delay for all parameters when 1 |
| wr_en | input | 1 | Shadow register write strobe |
| wr_ch | input | 1 | Channel written |
| wr_field | input | 2 | Shadow register select (see R10) |
| wr_data | input | 32 | Write value, low-aligned |
| io_update | input | 1 | Transfer request, sampled at sync_clk rise |
| sync_clk | output | 1 | Quarter-rate sync clock |
| samples | output | 20 | Channel 0 sample in [9:0], channel 1 in [19:10], signed |

## Verification
The hardest case to produce is a sustained frequency run in which the accumulator wraps past 2^32 while the output is compared against the closed-form phase on every cycle. The stimulus gets there by starting from a frozen accumulator at zero with zero phase and full scale. It then transfers two large frequency words, so one channel wraps within the window. From that same sync edge, the bench checks every sample of both channels: zero before cycle 29, and the model value at each cycle after. Exact latency measurement relies on choosing old and new settings whose outputs differ at the first affected sample, which fixes the cycle of the first change.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    FLD_FREQ  = 2'd0,
    FLD_PHASE = 2'd1,
    FLD_AMP   = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;
endpackage

// File: rtl/dds_sync_ctrl.sv
module dds_sync_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_en,
  input  logic io_update,
  output logic sync_clk,
  output logic load
);
  logic [1:0] cnt_q, cnt_d;
  logic       sclk_q, sclk_d;
  logic       upd_q, upd_d;
  logic       tick;

  always_comb begin
    cnt_d  = cnt_q + 2'd1;
    tick   = (cnt_q == 2'd1);
    sclk_d = sync_en & cnt_d[1];
    upd_d  = tick ? io_update : upd_q;
    load   = tick & io_update & ~upd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 2'd0;
      sclk_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      upd_q  <= upd_d;
    end
  end

  assign sync_clk = sclk_q;

  AST_LOAD_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n) load |=> !load); // R5
endmodule

// File: rtl/dds_param_bank.sv
module dds_param_bank #(
  parameter int FREQ_W = 32,
  parameter int PH_W   = 14,
  parameter int AMP_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        wr_field,
  input  logic [FREQ_W-1:0] wr_data,
  input  logic              load,
  output logic [FREQ_W-1:0] freq_a,
  output logic [PH_W-1:0]   ph_a,
  output logic [AMP_W-1:0]  amp_a
);
  import dds_pkg::*;
  localparam logic [AMP_W-1:0] AMP_FULL = {AMP_W{1'b1}};

  logic [FREQ_W-1:0] freq_sq, freq_sd, freq_aq, freq_ad;
  logic [PH_W-1:0]   ph_sq, ph_sd, ph_aq, ph_ad;
  logic [AMP_W-1:0]  amp_sq, amp_sd, amp_aq, amp_ad;
  fld_e              fld;

  always_comb begin
    fld     = fld_e'(wr_field);
    freq_sd = freq_sq;
    ph_sd   = ph_sq;
    amp_sd  = amp_sq;
    if (wr_hit) begin
      case (fld)
        FLD_FREQ:  freq_sd = wr_data;
        FLD_PHASE: ph_sd   = wr_data[PH_W-1:0];
        FLD_AMP:   amp_sd  = wr_data[AMP_W-1:0];
        default:   ;
      endcase
    end
    freq_ad = load ? freq_sq : freq_aq;
    ph_ad   = load ? ph_sq   : ph_aq;
    amp_ad  = load ? amp_sq  : amp_aq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_sq <= '0;
      ph_sq   <= '0;
      amp_sq  <= AMP_FULL;
      freq_aq <= '0;
      ph_aq   <= '0;
      amp_aq  <= AMP_FULL;
    end else begin
      freq_sq <= freq_sd;
      ph_sq   <= ph_sd;
      amp_sq  <= amp_sd;
      freq_aq <= freq_ad;
      ph_aq   <= ph_ad;
      amp_aq  <= amp_ad;
    end
  end

  assign freq_a = freq_aq;
  assign ph_a   = ph_aq;
  assign amp_a  = amp_aq;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({freq_a, ph_a, amp_a})); // R5
endmodule

// File: rtl/dds_delay_line.sv
module dds_delay_line #(
  parameter int W      = 8,
  parameter int D_FAST = 1,
  parameter int D_SLOW = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slow,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st_q [D_SLOW];
  logic [W-1:0] st_d [D_SLOW];

  always_comb begin
    st_d[0] = din;
    for (int i = 1; i < D_SLOW; i++) st_d[i] = st_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D_SLOW; i++) st_q[i] <= '0;
    end else begin
      for (int i = 0; i < D_SLOW; i++) st_q[i] <= st_d[i];
    end
  end

  generate
    if (D_FAST == D_SLOW) begin : g_single
      assign dout = st_q[D_SLOW-1];
    end else begin : g_dual
      assign dout = slow ? st_q[D_SLOW-1] : st_q[D_FAST-1];
    end
  endgenerate
endmodule

// File: rtl/dds_channel.sv
module dds_channel #(
  parameter int FREQ_W   = 32,
  parameter int PH_W     = 14,
  parameter int AMP_W    = 10,
  parameter int OUT_W    = 10,
  parameter int D_F      = 24,
  parameter int D_P_FAST = 21,
  parameter int D_P_SLOW = 25,
  parameter int D_A_FAST = 15,
  parameter int D_A_SLOW = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    match_lat,
  input  logic [FREQ_W-1:0]       freq_a,
  input  logic [PH_W-1:0]         ph_a,
  input  logic [AMP_W-1:0]        amp_a,
  output logic signed [OUT_W-1:0] sample
);
  localparam int IDX_W  = OUT_W;
  localparam int ADDR_W = IDX_W + 2;
  localparam int MAG_W  = IDX_W - 1;
  localparam int SQ_W   = 2 * IDX_W + 4;
  localparam int PROD_W = OUT_W + AMP_W + 1;
  localparam logic [IDX_W+1:0] FULL = (IDX_W + 2)'(1) << (IDX_W + 1);

  logic [FREQ_W-1:0] freq_d;
  logic [PH_W-1:0]   ph_d;
  logic [AMP_W-1:0]  amp_d;

  dds_delay_line #(.W(FREQ_W), .D_FAST(D_F), .D_SLOW(D_F)) u_dl_freq (
    .clk(clk), .rst_n(rst_n), .slow(match_lat), .din(freq_a), .dout(freq_d));
  dds_delay_line #(.W(PH_W), .D_FAST(D_P_FAST), .D_SLOW(D_P_SLOW)) u_dl_ph (
    .clk(clk), .rst_n(rst_n), .slow(match_lat), .din(ph_a), .dout(ph_d));
  dds_delay_line #(.W(AMP_W), .D_FAST(D_A_FAST), .D_SLOW(D_A_SLOW)) u_dl_amp (
    .clk(clk), .rst_n(rst_n), .slow(match_lat), .din(amp_a), .dout(amp_d));

  logic [FREQ_W-1:0]       acc_q, acc_d;
  logic [PH_W-1:0]         pw_q, pw_d;
  logic signed [OUT_W-1:0] sin_q, sin_d;
  logic signed [PROD_W-1:0] prod_q, prod_d;
  logic signed [OUT_W-1:0] out_q, out_d;

  logic [ADDR_W-1:0] addr;
  logic [1:0]        quad;
  logic [IDX_W-1:0]  idx, u;
  logic [IDX_W+1:0]  u_w, comp;
  logic [SQ_W-1:0]   sq;
  logic [MAG_W-1:0]  mag;
  logic signed [OUT_W-1:0]  mag_s;
  logic signed [AMP_W:0]    amp_s;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    acc_d = acc_q + freq_d;
    pw_d  = acc_q[FREQ_W-1 -: PH_W] + ph_d;

    addr  = pw_q[PH_W-1 -: ADDR_W];
    quad  = addr[ADDR_W-1 -: 2];
    idx   = addr[IDX_W-1:0];
    u     = quad[0] ? ~idx : idx;
    u_w   = {2'b00, u};
    comp  = FULL - u_w;
    sq    = SQ_W'(u_w) * SQ_W'(comp);
    mag   = sq[IDX_W+1 +: MAG_W];
    mag_s = $signed({1'b0, mag});
    sin_d = quad[1] ? -mag_s : mag_s;

    amp_s   = $signed({1'b0, amp_d});
    prod_d  = sin_q * amp_s;
    shifted = prod_q >>> AMP_W;
    out_d   = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pw_q   <= '0;
      sin_q  <= '0;
      prod_q <= '0;
      out_q  <= '0;
    end else begin
      acc_q  <= acc_d;
      pw_q   <= pw_d;
      sin_q  <= sin_d;
      prod_q <= prod_d;
      out_q  <= out_d;
    end
  end

  assign sample = out_q;

  AST_SAMPLE_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
    sample != {1'b1, {(OUT_W-1){1'b0}}}); // R3
  AST_SINE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_q <= $signed({1'b0, {MAG_W{1'b1}}})) && (sin_q >= -$signed({1'b0, {MAG_W{1'b1}}}))); // R2
  AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_d == '0) |=> ##1 (sample == '0)); // R3
endmodule

// File: rtl/dual_dds_core.sv
module dual_dds_core #(
  parameter int NUM_CH    = 2,
  parameter int FREQ_W    = 32,
  parameter int PH_W      = 14,
  parameter int AMP_W     = 10,
  parameter int OUT_W     = 10,
  parameter int LAT_FREQ  = 29,
  parameter int LAT_PHASE = 25,
  parameter int LAT_AMP   = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_en,
  input  logic                    match_lat,
  input  logic                    wr_en,
  input  logic                    wr_ch,
  input  logic [1:0]              wr_field,
  input  logic [FREQ_W-1:0]       wr_data,
  input  logic                    io_update,
  output logic                    sync_clk,
  output logic [NUM_CH*OUT_W-1:0] samples
);
  localparam int D_F      = LAT_FREQ - 5;
  localparam int D_P_FAST = LAT_PHASE - 4;
  localparam int D_P_SLOW = LAT_FREQ - 4;
  localparam int D_A_FAST = LAT_AMP - 2;
  localparam int D_A_SLOW = LAT_FREQ - 2;

  logic rs_q1, rs_q2;
  logic rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_i_n = rs_q2;

  logic load;

  dds_sync_ctrl u_sync (
    .clk(clk), .rst_n(rst_i_n), .sync_en(sync_en), .io_update(io_update),
    .sync_clk(sync_clk), .load(load));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic              hit;
      logic [FREQ_W-1:0] freq_a;
      logic [PH_W-1:0]   ph_a;
      logic [AMP_W-1:0]  amp_a;
      logic signed [OUT_W-1:0] smp;

      assign hit = wr_en && (int'(wr_ch) == g);

      dds_param_bank #(.FREQ_W(FREQ_W), .PH_W(PH_W), .AMP_W(AMP_W)) u_bank (
        .clk(clk), .rst_n(rst_i_n), .wr_hit(hit), .wr_field(wr_field),
        .wr_data(wr_data), .load(load),
        .freq_a(freq_a), .ph_a(ph_a), .amp_a(amp_a));

      dds_channel #(
        .FREQ_W(FREQ_W), .PH_W(PH_W), .AMP_W(AMP_W), .OUT_W(OUT_W),
        .D_F(D_F), .D_P_FAST(D_P_FAST), .D_P_SLOW(D_P_SLOW),
        .D_A_FAST(D_A_FAST), .D_A_SLOW(D_A_SLOW)
      ) u_chan (
        .clk(clk), .rst_n(rst_i_n), .match_lat(match_lat),
        .freq_a(freq_a), .ph_a(ph_a), .amp_a(amp_a), .sample(smp));

      assign samples[g*OUT_W +: OUT_W] = smp;
    end
  endgenerate

  AST_SYNC_MUTED: assert property (@(posedge clk) disable iff (!rst_i_n)
    !sync_en |=> !sync_clk); // R4
  AST_LOAD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (load && sync_en) |=> $rose(sync_clk)); // R6
endmodule

// File: tb/sim_dual_dds_core.sv
module sim_dual_dds_core;
  logic        clk = 1'b0;
  logic        rst_n, sync_en, match_lat, wr_en, wr_ch, io_update;
  logic [1:0]  wr_field;
  logic [31:0] wr_data;
  logic        sync_clk;
  logic [19:0] samples;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dual_dds_core u0 (
    .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .match_lat(match_lat),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_field(wr_field), .wr_data(wr_data),
    .io_update(io_update), .sync_clk(sync_clk), .samples(samples));

  function automatic int chv(int i);
    logic signed [9:0] v;
    v = (i == 0) ? samples[9:0] : samples[19:10];
    return int'(v);
  endfunction

  function automatic int wave(int p12, int amp);
    int q, idx, u, m, s;
    q = (p12 >> 10) & 3;
    idx = p12 & 1023;
    u = ((q & 1) != 0) ? 1023 - idx : idx;
    m = (u * (2048 - u)) >> 11;
    s = ((q & 2) != 0) ? -m : m;
    return (s * amp) >>> 10;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, int fld, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch[0]; wr_field = fld[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic upd_wait();
    @(negedge clk) io_update = 1'b1;
    repeat (8) @(negedge clk);
    io_update = 1'b0;
    repeat (45) @(negedge clk);
  endtask

  task automatic measure(output int l0, output int l1);
    int s0o, s1o;
    s0o = chv(0); s1o = chv(1); l0 = -1; l1 = -1;
    @(negedge clk) io_update = 1'b1;
    @(posedge sync_clk);
    for (int k = 1; k <= 60; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 6) io_update = 1'b0;
      if (l0 < 0 && chv(0) != s0o) l0 = k;
      if (l1 < 0 && chv(1) != s1o) l1 = k;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int l0, l1;
    rst_n = 1'b0; sync_en = 1'b1; match_lat = 1'b0; wr_en = 1'b0; wr_ch = 1'b0;
    wr_field = 2'd0; wr_data = '0; io_update = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 reset sample ch0", chv(0), 0);
    chk("R9 reset sample ch1", chv(1), 0);

    // R4 sync clock shape
    @(posedge sync_clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R4 sync_clk pattern", int'(sync_clk), ((k % 4) < 2) ? 1 : 0);
    end

    // R9 default full-scale amplitude, R10 phase field
    wr(0, 1, 32'h1000); wr(1, 1, 32'h1000);
    upd_wait();
    chk("R9 default amp ch0", chv(0), 510);
    chk("R9 default amp ch1", chv(1), 510);

    // R5 shadow isolation, R10 field code 3 ignored
    wr(0, 2, 32'd300);
    wr(0, 3, 32'hFFFF_FFFF);
    repeat (60) @(negedge clk);
    chk("R5 shadow not applied", chv(0), 510);
    measure(l0, l1);
    chk("R7 amplitude latency", l0, 17);
    chk("R3 amp scale value", chv(0), 149);
    chk("R5 other channel untouched", chv(1), 510);
    repeat (60) @(negedge clk);
    chk("R10 code 3 wrote nothing", chv(0), 149);

    // R5 held-high update causes no second transfer
    @(negedge clk) io_update = 1'b1;
    repeat (12) @(negedge clk);
    wr(0, 2, 32'd600);
    repeat (50) @(negedge clk);
    chk("R5 held update no transfer", chv(0), 149);
    io_update = 1'b0;
    repeat (8) @(negedge clk);
    measure(l0, l1);
    chk("R5 new edge transfers", chv(0), 299);

    // R6/R7 phase latency on both channels
    wr(0, 1, 32'h0800); wr(1, 1, 32'h0800);
    measure(l0, l1);
    chk("R7 phase latency ch0", l0, 25);
    chk("R6 phase latency ch1", l1, 25);
    chk("R2 phase value ch0", chv(0), 225);
    chk("R2 phase value ch1", chv(1), 383);

    wr(0, 2, 32'd100); wr(1, 2, 32'd50);
    measure(l0, l1);
    chk("R7 amp latency ch0", l0, 17);
    chk("R6 amp latency ch1", l1, 17);
    chk("R3 amp value ch0", chv(0), 37);
    chk("R3 amp value ch1", chv(1), 18);

    // R1 R2 R3 sweep of phase offsets and scales
    for (int i = 0; i < 64; i++) begin
      int p0, p1, a0, a1;
      p0 = (i * 257) & 16383; p1 = 16383 - i * 250;
      a0 = 1023 - i * 16;     a1 = i * 16 + 5;
      wr(0, 1, p0); wr(1, 1, p1); wr(0, 2, a0); wr(1, 2, a1);
      upd_wait();
      chk("R2 sweep ch0", chv(0), wave(p0 >> 2, a0));
      chk("R3 sweep ch1", chv(1), wave(p1 >> 2, a1));
    end

    // R8 matched latency
    wr(0, 2, 32'd800); wr(1, 2, 32'd800);
    wr(0, 1, 32'h1000); wr(1, 1, 32'h1000);
    upd_wait();
    match_lat = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 prep value", chv(0), 399);
    wr(0, 1, 32'h3000); wr(1, 1, 32'h3000);
    measure(l0, l1);
    chk("R8 matched phase latency ch0", l0, 29);
    chk("R8 matched phase latency ch1", l1, 29);
    chk("R2 negative half value", chv(0), -400);
    wr(0, 2, 32'd400); wr(1, 2, 32'd400);
    measure(l0, l1);
    chk("R8 matched amp latency ch0", l0, 29);
    chk("R8 matched amp latency ch1", l1, 29);
    chk("R3 floor of negative", chv(1), -200);

    // R4 sync clock muted, update still taken
    sync_en = 1'b0;
    repeat (2) @(negedge clk);
    begin
      int hi = 0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (sync_clk) hi++;
      end
      chk("R4 muted sync_clk high count", hi, 0);
    end
    wr(0, 1, 32'h1000); wr(1, 1, 32'h1000);
    upd_wait();
    chk("R4 update while muted", chv(0), 199);
    sync_en = 1'b1; match_lat = 1'b0;

    // R1 frequency run with wrap, R7 frequency latency
    wr(0, 1, 32'h0); wr(1, 1, 32'h0); wr(0, 2, 32'd1023); wr(1, 2, 32'd1023);
    upd_wait();
    chk("R1 frozen zero phase", chv(0), 0);
    wr(0, 0, 32'h0100_0000); wr(1, 0, 32'h0300_0000);
    begin
      int bad0 = 0, bad1 = 0, fa0 = 0, fe0 = 0, fa1 = 0, fe1 = 0;
      @(negedge clk) io_update = 1'b1;
      @(posedge sync_clk);
      for (int k = 1; k <= 340; k++) begin
        logic [31:0] a0, a1;
        int e0, e1;
        @(posedge clk);
        @(negedge clk);
        if (k == 6) io_update = 1'b0;
        a0 = (k < 29) ? 32'h0 : 32'(k - 28) * 32'h0100_0000;
        a1 = (k < 29) ? 32'h0 : 32'(k - 28) * 32'h0300_0000;
        e0 = wave(int'(a0 >> 20), 1023);
        e1 = wave(int'(a1 >> 20), 1023);
        if (chv(0) != e0 && bad0 == 0) begin fa0 = chv(0); fe0 = e0; end
        if (chv(1) != e1 && bad1 == 0) begin fa1 = chv(1); fe1 = e1; end
        if (chv(0) != e0) bad0++;
        if (chv(1) != e1) bad1++;
      end
      chk("R7 R1 frequency run ch0 first mismatch", fa0, fe0);
      chk("R1 frequency run ch1 first mismatch", fa1, fe1);
      chk("R1 frequency run ch0 mismatches", bad0, 0);
      chk("R6 frequency run ch1 mismatches", bad1, 0);
    end

    // R9 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 reset clears ch0", chv(0), 0);
    chk("R9 reset clears ch1", chv(1), 0);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    chk("R9 frequency default zero ch0", chv(0), 0);
    chk("R9 frequency default zero ch1", chv(1), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule